// File: doc/BRIEF.md
# DMA channel result and interrupt reporter

This block sits beside the command-list engines of a multi-channel DMA controller and records how each command list ended. When a channel's engine reports completion, the block stores a result word for that channel. The word marks it valid and notes whether the list failed and whether the top-level pointer list was done. It raises a per-channel pending flag and merges the channels that have interrupts enabled into one interrupt status word and a single interrupt line.

Software services the line in three steps. It reads the interrupt status word to find the channels, then each channel's status register, then the result register. Reading the result register pops the result. A second result that arrives before the first is read waits in a one-deep shadow slot. Writing a channel's flush register sends a one-cycle abort to that channel's engine. If flush reporting is enabled for the channel, the write also posts a result with the flushed bit set.

Top module: `dma_result_irq`

## Requirements
- R1: After reset no channel holds a result: every result, status and config register reads 0, the interrupt status word reads 0 and `irq_o` is low.
- R2: A pulse on `done_i[c]` posts a result for channel c. Its word reads with bit 31 (valid) set, bit 3 equal to `err_i[c]`, bit 1 equal to `tpd_i[c]` and bit 2 (flushed) clear. The channel's status register then reads bit 1 set (value 2).
- R3: Reading the result register of a channel that holds a result pops it. With nothing behind it, the next read of the result returns 0 and the status register returns 0.
- R4: A second result posted while one is unread is kept and returned by the read after the first. A third result posted while both slots are full is dropped.
- R5: The config register holds bit 0 (interrupt enable) and bit 1 (flush reporting enable). It reads back what was written in those two bits, and the other bits read 0.
- R6: Bit c of the interrupt status word is set when channel c holds a result and its interrupt enable is set. `irq_o` is the OR of the word. Writing 0 to the config register masks the channel without discarding its result.
- R7: A write to a channel's flush register drives `abort_o[c]` high for exactly the one cycle after the write, whatever the channel's enables are.
- R8: With flush reporting enabled, a flush write posts a result that reads 0x80000004. With it disabled, the flush posts nothing.
- R9: When a flush write with flush reporting enabled falls in the same cycle as `done_i[c]`, a single result is posted, and it is the flushed one.
- R10: When a pop of channel c and a new result for c fall in the same cycle, the read returns the older result and the new one is returned by the next read.
- R11: `addr_i[6:4]` selects the register and `addr_i[3:0]` the channel: 0 result, 1 status, 2 config, 3 flush (write only), 4 interrupt status word. Other selects read 0 and ignore writes. Read data appears on `rdata_o` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | NUM_CH | Per-channel command list finished pulse |
| err_i | input | NUM_CH | Error qualifier, sampled with done_i |
| tpd_i | input | NUM_CH | Top-level pointer done qualifier, sampled with done_i |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | CH_W+3 | Register select and channel index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| abort_o | output | NUM_CH | One-cycle abort to the channel engine |
| irq_o | output | 1 | Shared interrupt line |

## Verification
Two pairs of events can land in the same cycle on one channel. A pop can coincide with a new result, and a flush write can coincide with a completion. The bench provokes both by driving `done_i` in the same cycle as the register request. For the pop case, it judges that the read returns the older word and the following read the newer one, with nothing lost or repeated. For the flush case, it judges that exactly one flushed result appears, or the plain completion result when flush reporting is off.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;
  typedef struct packed {
    logic err;
    logic flushed;
    logic tpd;
  } rslt_t;

  localparam int RES_VALID_BIT = 31;
  localparam int RES_ERR_BIT   = 3;
  localparam int RES_FLUSH_BIT = 2;
  localparam int RES_TPD_BIT   = 1;
  localparam int STAT_PEND_BIT = 1;

  localparam logic [2:0] SEL_RESULT = 3'd0;
  localparam logic [2:0] SEL_STATUS = 3'd1;
  localparam logic [2:0] SEL_CONFIG = 3'd2;
  localparam logic [2:0] SEL_FLUSH  = 3'd3;
  localparam logic [2:0] SEL_IRQ    = 3'd4;

  function automatic logic [31:0] pack_res(input logic v, input rslt_t r);
    logic [31:0] w;
    w = '0;
    w[RES_VALID_BIT] = v;
    w[RES_ERR_BIT]   = v & r.err;
    w[RES_FLUSH_BIT] = v & r.flushed;
    w[RES_TPD_BIT]   = v & r.tpd;
    return w;
  endfunction
endpackage

// File: rtl/rr_slot.sv
module rr_slot
  import dma_rr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  post_i,
  input  rslt_t word_i,
  input  logic  pop_i,
  output logic  vis_v_o,
  output rslt_t vis_o,
  output logic  sh_v_o
);
  logic  vis_v_q, sh_v_q;
  rslt_t vis_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_v_q <= 1'b0;
      sh_v_q  <= 1'b0;
      vis_q   <= '0;
      sh_q    <= '0;
    end else if (pop_i && vis_v_q) begin
      if (sh_v_q) begin
        vis_q  <= sh_q;
        sh_v_q <= post_i;
        if (post_i) sh_q <= word_i;
      end else begin
        vis_v_q <= post_i;
        if (post_i) vis_q <= word_i;
      end
    end else if (post_i) begin
      if (!vis_v_q) begin
        vis_v_q <= 1'b1;
        vis_q   <= word_i;
      end else if (!sh_v_q) begin
        sh_v_q <= 1'b1;
        sh_q   <= word_i;
      end
      // both slots full: newest result dropped
    end
  end

  assign vis_v_o = vis_v_q;
  assign vis_o   = vis_q;
  assign sh_v_o  = sh_v_q;
endmodule

// File: rtl/rr_regs.sv
module rr_regs
  import dma_rr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  input  logic [NUM_CH-1:0]       vis_v_i,
  input  rslt_t [NUM_CH-1:0]      vis_w_i,
  output logic [31:0]             rdata_o,
  output logic [NUM_CH-1:0]       pop_o,
  output logic [NUM_CH-1:0]       flush_req_o,
  output logic [NUM_CH-1:0]       cfg_irq_o,
  output logic [NUM_CH-1:0]       cfg_fl_o,
  output logic [NUM_CH-1:0]       abort_o,
  output logic [NUM_CH-1:0]       irq_word_o
);
  logic [2:0]      sel;
  logic [CH_W-1:0] ch;
  logic            ch_ok;
  logic [31:0]     rd_val;
  logic [NUM_CH-1:0] cfg_irq_q, cfg_fl_q, abort_q;
  logic            unused_wdata;

  assign sel          = addr_i[ADDR_W-1 -: 3];
  assign ch           = addr_i[CH_W-1:0];
  assign ch_ok        = (32'(ch) < NUM_CH);
  assign unused_wdata = ^wdata_i[31:2];
  assign irq_word_o   = vis_v_i & cfg_irq_q;

  always_comb begin
    pop_o       = '0;
    flush_req_o = '0;
    if (req_i && ch_ok) begin
      if (!we_i && sel == SEL_RESULT && vis_v_i[ch]) pop_o[ch] = 1'b1;
      if (we_i && sel == SEL_FLUSH) flush_req_o[ch] = 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_RESULT: if (ch_ok) rd_val = pack_res(vis_v_i[ch], vis_w_i[ch]);
      SEL_STATUS: if (ch_ok) rd_val[STAT_PEND_BIT] = vis_v_i[ch];
      SEL_CONFIG: if (ch_ok) rd_val[1:0] = {cfg_fl_q[ch], cfg_irq_q[ch]};
      SEL_IRQ:    rd_val[NUM_CH-1:0] = irq_word_o;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_irq_q <= '0;
      cfg_fl_q  <= '0;
      abort_q   <= '0;
      rdata_o   <= '0;
    end else begin
      abort_q <= flush_req_o;
      if (req_i && !we_i) rdata_o <= rd_val;
      if (req_i && we_i && sel == SEL_CONFIG && ch_ok) begin
        cfg_irq_q[ch] <= wdata_i[0];
        cfg_fl_q[ch]  <= wdata_i[1];
      end
    end
  end

  assign cfg_irq_o = cfg_irq_q;
  assign cfg_fl_o  = cfg_fl_q;
  assign abort_o   = abort_q;
endmodule

// File: rtl/dma_result_irq.sv
module dma_result_irq
  import dma_rr_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] err_i,
  input  logic [NUM_CH-1:0] tpd_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] abort_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0]  vis_v, sh_v, pop, flush_req, cfg_irq, cfg_fl, irq_word;
  rslt_t [NUM_CH-1:0] vis_w;

  rr_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .vis_v_i     (vis_v),
    .vis_w_i     (vis_w),
    .rdata_o     (rdata_o),
    .pop_o       (pop),
    .flush_req_o (flush_req),
    .cfg_irq_o   (cfg_irq),
    .cfg_fl_o    (cfg_fl),
    .abort_o     (abort_o),
    .irq_word_o  (irq_word)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic  fl_post, post;
    rslt_t word;
    // flush outranks a completion in the same cycle
    assign fl_post = flush_req[c] & cfg_fl[c];
    assign post    = fl_post | done_i[c];
    assign word    = fl_post ? rslt_t'{err: 1'b0, flushed: 1'b1, tpd: 1'b0}
                             : rslt_t'{err: err_i[c], flushed: 1'b0, tpd: tpd_i[c]};

    rr_slot i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .post_i  (post),
      .word_i  (word),
      .pop_i   (pop[c]),
      .vis_v_o (vis_v[c]),
      .vis_o   (vis_w[c]),
      .sh_v_o  (sh_v[c])
    );
  end

  assign irq_o = |irq_word;
endmodule

// File: rtl/dma_result_irq_chk.sv
module dma_result_irq_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  localparam int ADDR_W = CH_W + 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] done_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] abort_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] vis_v,
  input logic [NUM_CH-1:0] sh_v,
  input logic [NUM_CH-1:0] cfg_irq
);
  logic [2:0]      sel;
  logic [CH_W-1:0] ch;
  logic            ch_ok, fl_wr, res_rd, unused_bits;

  assign sel         = addr_i[ADDR_W-1 -: 3];
  assign ch          = addr_i[CH_W-1:0];
  assign ch_ok       = (32'(ch) < NUM_CH);
  assign fl_wr       = req_i && we_i && sel == 3'd3 && ch_ok;
  assign res_rd      = req_i && !we_i && sel == 3'd0 && ch_ok;
  assign unused_bits = ^rdata_o[30:0];

  // R7
  flush_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr |=> ($onehot(abort_o) && abort_o[$past(ch)]));
  // R7
  no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_wr |=> (abort_o == '0));
  // R4
  shadow_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sh_v & ~vis_v) == '0));
  // R6
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vis_v & cfg_irq) == '0) |-> !irq_o);
  // R6
  irq_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vis_v & cfg_irq) != '0) |-> irq_o);
  // R11
  read_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_rd |=> (rdata_o[31] == $past(vis_v[ch])));
  // R3
  pop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_rd && vis_v[ch] && !sh_v[ch] && !done_i[ch]) |=> !vis_v[$past(ch)]);
endmodule

bind dma_result_irq dma_result_irq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_i  (done_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .abort_o (abort_o),
  .irq_o   (irq_o),
  .vis_v   (vis_v),
  .sh_v    (sh_v),
  .cfg_irq (cfg_irq)
);

// File: tb/test_dma_result_irq.sv
`timescale 1ns/1ps
module test_dma_result_irq;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  done = '0, err = '0, tpd = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [6:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  abort;
  logic          irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_result_irq #(.NUM_CH(N)) i_dma_result_irq (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .err_i(err), .tpd_i(tpd),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .abort_o(abort), .irq_o(irq)
  );

  function automatic logic [6:0] adr(input int sel, input int c);
    return {3'(sel), 4'(c)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic op(input logic r, input logic w, input logic [6:0] a, input logic [31:0] d,
                    input logic [N-1:0] dn, input logic [N-1:0] er, input logic [N-1:0] tp,
                    output logic [31:0] q);
    req = r; we = w; addr = a; wdata = d; done = dn; err = er; tpd = tp;
    @(negedge clk);
    q = rdata;
    req = 0; we = 0; done = '0; err = '0; tpd = '0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] q;
    op(1, 1, a, d, '0, '0, '0, q);
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] q);
    op(1, 0, a, '0, '0, '0, '0, q);
  endtask

  task automatic ev(input logic [N-1:0] dn, input logic [N-1:0] er, input logic [N-1:0] tp);
    logic [31:0] q;
    op(0, 0, '0, '0, dn, er, tp, q);
  endtask

  function automatic logic [31:0] res_word(input logic e, input logic f, input logic t);
    return 32'h8000_0000 | (32'(e) << 3) | (32'(f) << 2) | (32'(t) << 1);
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 abort", 32'(abort), 0);
    rd(adr(4, 0), q); chk("R1 irq word", q, 0);
    for (int c = 0; c < N; c++) begin
      rd(adr(0, c), q); chk("R1 result", q, 0);
      rd(adr(1, c), q); chk("R1 status", q, 0);
      rd(adr(2, c), q); chk("R1 config", q, 0);
    end

    // R5 config readback, upper bits ignored
    for (int c = 0; c < N; c++) wr(adr(2, c), 32'hFFFF_FFFC | 32'(c % 4));
    for (int c = 0; c < N; c++) begin
      rd(adr(2, c), q); chk("R5 config", q, 32'(c % 4));
    end

    // R2 R3 R6 post, report, pop per channel
    for (int c = 0; c < N; c++) begin
      logic e, t;
      e = c[0]; t = c[1];
      ev(N'(1) << c, e ? N'(1) << c : '0, t ? N'(1) << c : '0);
      chk("R6 irq_o", 32'(irq), 32'(c[0]));
      rd(adr(4, 0), q); chk("R6 irq word", q, c[0] ? 32'(1) << c : 0);
      rd(adr(1, c), q); chk("R2 status", q, 2);
      rd(adr(0, c), q); chk("R2 result", q, res_word(e, 0, t));
      rd(adr(0, c), q); chk("R3 popped", q, 0);
      rd(adr(1, c), q); chk("R3 status clear", q, 0);
      chk("R3 irq_o", 32'(irq), 0);
    end

    // R4 shadow keeps second, third dropped
    for (int c = 0; c < N; c++) begin
      ev(N'(1) << c, N'(1) << c, '0);
      ev(N'(1) << c, '0, N'(1) << c);
      ev(N'(1) << c, N'(1) << c, N'(1) << c);
      rd(adr(0, c), q); chk("R4 first", q, res_word(1, 0, 0));
      rd(adr(0, c), q); chk("R4 second", q, res_word(0, 0, 1));
      rd(adr(0, c), q); chk("R4 third dropped", q, 0);
    end

    // R7 R8 flush with and without reporting
    for (int c = 0; c < N; c++) begin
      wr(adr(2, c), c[0] ? 32'd2 : 32'd0);
      wr(adr(3, c), 32'h0);
      chk("R7 abort pulse", 32'(abort), 32'(1) << c);
      @(negedge clk);
      chk("R7 abort one cycle", 32'(abort), 0);
      rd(adr(0, c), q); chk("R8 flush result", q, c[0] ? 32'h8000_0004 : 0);
      rd(adr(0, c), q); chk("R8 after pop", q, 0);
    end

    // R9 flush and done in the same cycle
    for (int c = 0; c < N; c++) begin
      op(1, 1, adr(3, c), '0, N'(1) << c, N'(1) << c, N'(1) << c, q);
      rd(adr(0, c), q); chk("R9 single result", q, c[0] ? 32'h8000_0004 : res_word(1, 0, 1));
      rd(adr(0, c), q); chk("R9 only one", q, 0);
    end

    // R10 pop and post in the same cycle, with and without shadow
    for (int c = 0; c < N; c++) begin
      ev(N'(1) << c, N'(1) << c, '0);
      op(1, 0, adr(0, c), '0, N'(1) << c, '0, N'(1) << c, q);
      chk("R10 older first", q, res_word(1, 0, 0));
      ev(N'(1) << c, N'(1) << c, N'(1) << c);
      op(1, 0, adr(0, c), '0, N'(1) << c, '0, '0, q);
      chk("R10 older again", q, res_word(0, 0, 1));
      rd(adr(0, c), q); chk("R10 shadow next", q, res_word(1, 0, 1));
      rd(adr(0, c), q); chk("R10 newest", q, res_word(0, 0, 0));
      rd(adr(0, c), q); chk("R10 empty", q, 0);
    end

    // R6 all channels, then masking
    for (int c = 0; c < N; c++) wr(adr(2, c), 32'd1);
    ev('1, '0, '0);
    rd(adr(4, 0), q); chk("R6 all pending", q, 32'h0000_FFFF);
    chk("R6 irq_o all", 32'(irq), 1);
    for (int c = 0; c < N; c++) wr(adr(2, c), 32'd0);
    chk("R6 masked irq_o", 32'(irq), 0);
    rd(adr(4, 0), q); chk("R6 masked word", q, 0);
    for (int c = 0; c < N; c++) begin
      rd(adr(1, c), q); chk("R6 result kept", q, 2);
      rd(adr(0, c), q); chk("R6 drain", q, res_word(0, 0, 0));
    end

    // R11 unused selects read 0, writes ignored
    for (int s = 5; s < 8; s++) begin
      for (int c = 0; c < N; c++) begin
        wr(adr(s, c), 32'hFFFF_FFFF);
        chk("R11 no abort", 32'(abort), 0);
        rd(adr(s, c), q); chk("R11 read zero", q, 0);
        rd(adr(2, c), q); chk("R11 config untouched", q, 0);
        rd(adr(0, c), q); chk("R11 no result", q, 0);
      end
    end

    report();
  end
endmodule